// File: doc/BRIEF.md
# Multi-lane SPI byte capture

This block is the receive front end of an SPI device. It is clocked directly by the serial clock and assembles incoming bits into bytes, taking one, two or four bits per sampling edge from up to four data lanes. The clock polarity and phase pair, the lane width and the direction of the traffic being captured (host-to-device or device-response) are configuration inputs that are held steady while chip select is asserted.

Each completed byte appears on a byte output together with a one-cycle valid strike and a flag telling whether it came from the response lane. The byte and its flag are held until the next byte completes. Chip select high acts as an asynchronous clear of the bit counter and the valid strike, so a partial byte never leaks into the next frame. An illegal lane-width setting raises an error flag and stops all capture.

Top module: `spi_cap`

## Requirements
- R1: The clock mode is mode_i = {CPOL, CPHA} (bit 1 is CPOL). Modes 0 and 3 capture lane data on the rising edge of sck_i; modes 1 and 2 capture on the falling edge.
- R2: Bits fill the byte from bit 7 down to bit 0; a byte completes on the sampling edge that fills bit 0, and byte_o then equals the assembled byte.
- R3: With lanes_i = 0 (one lane), each edge takes one bit: from sio_i[0] when rsp_sel_i = 0 and from sio_i[1] when rsp_sel_i = 1; the other lanes have no effect on byte_o.
- R4: With lanes_i = 1 (two lanes), each edge takes two bits, sio_i[1] into the higher and sio_i[0] into the lower position; sio_i[3:2] have no effect. A byte takes four edges.
- R5: With lanes_i = 2 (four lanes), each edge takes four bits with sio_i[3] highest down to sio_i[0] lowest; a byte takes two edges.
- R6: lanes_i = 3 is illegal: lane_err_o is high while it is applied, no bits are captured, byte_vld_o stays low and byte_o is unchanged.
- R7: Raising csb_i discards any partial byte and clears byte_vld_o at once; the next frame starts a fresh byte at bit 7.
- R8: byte_vld_o rises on the edge that completes a byte and falls on the next sampling edge.
- R9: byte_o and rsp_o (equal to rsp_sel_i at the completing edge) hold their value until the next byte completes, including across chip-select deassertion.
- R10: While rst_ni is low, byte_o, byte_vld_o and rsp_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of all state |
| csb_i | input | 1 | Active-low chip select; high clears the capture state |
| sck_i | input | 1 | Serial clock, also the capture clock |
| mode_i | input | 2 | {CPOL, CPHA} clock mode |
| lanes_i | input | 2 | Lane width: 0 one, 1 two, 2 four, 3 illegal |
| rsp_sel_i | input | 1 | Single-lane source: 0 host line (lane 0), 1 response line (lane 1) |
| sio_i | input | 4 | Serial data lanes |
| byte_o | output | BYTE_W | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strike per completed byte |
| rsp_o | output | 1 | Response-line flag of the last completed byte |
| lane_err_o | output | 1 | Illegal lane-width setting |

## Verification
Byte completion and the start of the following byte share a sampling edge boundary: the edge after a completion must drop the valid strike while loading the first bits of the next byte without disturbing the held value. Each vector frame sends two bytes back to back and judges, right after the first edge of the second byte, that valid is low and byte_o still shows the first byte. The second overlap, a valid strike still standing when chip select is raised, is provoked by deasserting select directly after a completed byte and judged by valid clearing at once while byte_o and rsp_o keep their values.

// File: rtl/spi_cap_pkg.sv
package spi_cap_pkg;
  localparam int unsigned NUM_SIO = 4;
  localparam int unsigned STEP_W  = 3;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_BAD = 2'd3
  } lane_cfg_e;
endpackage

// File: rtl/spi_cap_clk.sv
module spi_cap_clk (
  input  logic       rst_ni,
  input  logic       csb_i,
  input  logic       sck_i,
  input  logic [1:0] mode_i,
  output logic       samp_clk_o,
  output logic       arst_no
);
  // modes 1 and 2 sample on the falling edge: invert the clock for them
  assign samp_clk_o = sck_i ^ mode_i[1] ^ mode_i[0];
  assign arst_no    = rst_ni & ~csb_i;
endmodule

// File: rtl/spi_cap_lanes.sv
module spi_cap_lanes
  import spi_cap_pkg::*;
(
  input  logic [1:0]         lanes_i,
  input  logic               rsp_sel_i,
  input  logic [NUM_SIO-1:0] sio_i,
  output logic [NUM_SIO-1:0] bits_o,
  output logic [STEP_W-1:0]  step_o,
  output logic               err_o
);
  always_comb begin
    bits_o = '0;
    step_o = '0;
    err_o  = 1'b0;
    unique case (lane_cfg_e'(lanes_i))
      LANE_X1: begin
        bits_o[0] = rsp_sel_i ? sio_i[1] : sio_i[0];
        step_o    = STEP_W'(1);
      end
      LANE_X2: begin
        bits_o[1:0] = sio_i[1:0];
        step_o      = STEP_W'(2);
      end
      LANE_X4: begin
        bits_o = sio_i;
        step_o = STEP_W'(4);
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_cap_shift.sv
module spi_cap_shift
  import spi_cap_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W + NUM_SIO)
) (
  input  logic               clk_i,
  input  logic               arst_ni,
  input  logic               rst_ni,
  input  logic [NUM_SIO-1:0] bits_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic               hold_i,
  input  logic               rsp_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               vld_o,
  output logic               rsp_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [BYTE_W-1:0] sh_q, acc;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              vld_q, done;
  logic [BYTE_W-1:0] byte_q;
  logic              rsp_q;

  always_comb begin
    acc    = (sh_q << step_i) | BYTE_W'(bits_i);
    cnt_nx = cnt_q + CNT_W'(step_i);
    done   = !hold_i && (cnt_nx == CNT_W'(BYTE_W));
  end

  // frame state: cleared by chip select
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else if (hold_i) begin
      vld_q <= 1'b0;
    end else begin
      sh_q  <= acc;
      cnt_q <= done ? '0 : cnt_nx;
      vld_q <= done;
    end
  end

  // result: survives chip select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      rsp_q  <= 1'b0;
    end else if (done) begin
      byte_q <= acc;
      rsp_q  <= rsp_i;
    end
  end

  assign byte_o = byte_q;
  assign vld_o  = vld_q;
  assign rsp_o  = rsp_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spi_cap.sv
module spi_cap
  import spi_cap_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic               rst_ni,
  input  logic               csb_i,
  input  logic               sck_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         lanes_i,
  input  logic               rsp_sel_i,
  input  logic [NUM_SIO-1:0] sio_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               byte_vld_o,
  output logic               rsp_o,
  output logic               lane_err_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + NUM_SIO);

  logic               samp_clk, arst_n;
  logic [NUM_SIO-1:0] bits;
  logic [STEP_W-1:0]  step;
  logic               lane_err;
  logic [CNT_W-1:0]   cnt;

  spi_cap_clk u_clk (
    .rst_ni     (rst_ni),
    .csb_i      (csb_i),
    .sck_i      (sck_i),
    .mode_i     (mode_i),
    .samp_clk_o (samp_clk),
    .arst_no    (arst_n)
  );

  spi_cap_lanes u_lanes (
    .lanes_i   (lanes_i),
    .rsp_sel_i (rsp_sel_i),
    .sio_i     (sio_i),
    .bits_o    (bits),
    .step_o    (step),
    .err_o     (lane_err)
  );

  spi_cap_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i   (samp_clk),
    .arst_ni (arst_n),
    .rst_ni  (rst_ni),
    .bits_i  (bits),
    .step_i  (step),
    .hold_i  (lane_err),
    .rsp_i   (rsp_sel_i),
    .byte_o  (byte_o),
    .vld_o   (byte_vld_o),
    .rsp_o   (rsp_o),
    .cnt_o   (cnt)
  );

  assign lane_err_o = lane_err;
endmodule

// File: rtl/spi_cap_chk.sv
module spi_cap_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              samp_clk_i,
  input logic              arst_ni,
  input logic              rst_ni,
  input logic              csb_i,
  input logic [1:0]        lanes_i,
  input logic              err_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              vld_i,
  input logic              rsp_i
);
  assert_vld_single_R8: assert property (@(posedge samp_clk_i) disable iff (!arst_ni)
    vld_i |=> !vld_i);

  assert_hold_mid_byte_R9: assert property (@(posedge samp_clk_i) disable iff (!arst_ni)
    (cnt_i != '0) |-> ($stable(byte_i) && $stable(rsp_i)));

  assert_err_no_byte_R6: assert property (@(posedge samp_clk_i) disable iff (!arst_ni)
    err_i |=> !vld_i);

  assert_cnt_range_R2: assert property (@(posedge samp_clk_i) disable iff (!arst_ni)
    cnt_i < CNT_W'(BYTE_W));

  assert_cs_clear_R7: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    csb_i |-> (!vld_i && cnt_i == '0));

  assert_quad_two_edges_R5: assert property (@(posedge samp_clk_i) disable iff (!arst_ni)
    (lanes_i == 2'd2 && cnt_i == CNT_W'(BYTE_W - 4)) |=> vld_i);
endmodule

bind spi_cap spi_cap_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .samp_clk_i (samp_clk),
  .arst_ni    (arst_n),
  .rst_ni     (rst_ni),
  .csb_i      (csb_i),
  .lanes_i    (lanes_i),
  .err_i      (lane_err),
  .cnt_i      (cnt),
  .byte_i     (byte_o),
  .vld_i      (byte_vld_o),
  .rsp_i      (rsp_o)
);

// File: tb/sim_spi_cap.sv
module sim_spi_cap;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       csb_i = 1'b1;
  logic       sck_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [1:0] lanes_i = 2'd0;
  logic       rsp_sel_i = 1'b0;
  logic [3:0] sio_i = 4'h0;
  logic [7:0] byte_o;
  logic       byte_vld_o, rsp_o, lane_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_cap #(.BYTE_W(8)) u0 (
    .rst_ni, .csb_i, .sck_i, .mode_i, .lanes_i, .rsp_sel_i, .sio_i,
    .byte_o, .byte_vld_o, .rsp_o, .lane_err_o
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] lanes;
    logic       rsp;
    logic [7:0] d0;
    logic [7:0] d1;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 1'b0, 8'hA5, 8'h3C},
    '{2'd1, 2'd0, 1'b1, 8'h96, 8'hF0},
    '{2'd2, 2'd1, 1'b0, 8'h5A, 8'hC3},
    '{2'd3, 2'd1, 1'b0, 8'h81, 8'h7E},
    '{2'd0, 2'd2, 1'b0, 8'h12, 8'hED},
    '{2'd3, 2'd2, 1'b1, 8'hBE, 8'hEF},
    '{2'd1, 2'd2, 1'b0, 8'h0F, 8'hF0},
    '{2'd2, 2'd0, 1'b1, 8'h01, 8'h80}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string lane_req(input logic [1:0] l);
    return (l == 2'd0) ? "R3" : (l == 2'd1) ? "R4" : (l == 2'd2) ? "R5" : "R6";
  endfunction

  // one bit period: data is set up before the sampling edge of the mode
  task automatic bit_period(input logic [1:0] mode, input logic [3:0] v);
    if (!mode[0]) begin
      @(negedge clk) sio_i = v;
      @(negedge clk) sck_i = ~mode[1];
      @(negedge clk) sck_i = mode[1];
    end else begin
      @(negedge clk) sck_i = ~mode[1];
      @(negedge clk) sio_i = v;
      @(negedge clk) sck_i = mode[1];
    end
  endtask

  task automatic send_bits(input logic [1:0] mode, input logic [1:0] lanes, input logic rsp,
                           input logic [7:0] d, input int periods,
                           input bit mid_chk, input logic [7:0] prev);
    for (int g = 0; g < periods; g++) begin
      logic [3:0] v;
      logic b;
      case (lanes)
        2'd0: begin
          b = d[7-g];
          v = rsp ? {2'b11, b, ~b} : {2'b11, ~b, b};
        end
        2'd1: v = {2'b11, d[7-2*g], d[6-2*g]};
        2'd2: v = d[7-4*g -: 4];
        default: v = {3'b000, d[7-g]};
      endcase
      bit_period(mode, v);
      if (mid_chk && g == 0) begin
        @(posedge clk);
        chk("R8", "valid after next edge", 32'(byte_vld_o), 32'd0);
        chk("R9", "byte held mid-byte", 32'(byte_o), 32'(prev));
      end
    end
  endtask

  function automatic int periods_for(input logic [1:0] lanes);
    return (lanes == 2'd1) ? 4 : (lanes == 2'd2) ? 2 : 8;
  endfunction

  task automatic open_frame(input logic [1:0] mode, input logic [1:0] lanes, input logic rsp);
    @(negedge clk);
    csb_i = 1'b1;
    mode_i = mode; lanes_i = lanes; rsp_sel_i = rsp;
    sck_i = mode[1];
    @(negedge clk) csb_i = 1'b0;
  endtask

  task automatic close_frame();
    @(negedge clk) csb_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(posedge clk);
    chk("R10", "byte in reset", 32'(byte_o), 32'd0);
    chk("R10", "valid in reset", 32'(byte_vld_o), 32'd0);
    chk("R10", "rsp in reset", 32'(rsp_o), 32'd0);
    @(negedge clk) rst_ni = 1'b1;

    // vector table: two bytes per frame, back to back
    foreach (VECS[i]) begin
      vec_t t = VECS[i];
      int p = periods_for(t.lanes);
      open_frame(t.mode, t.lanes, t.rsp);
      send_bits(t.mode, t.lanes, t.rsp, t.d0, p, 1'b0, 8'h00);
      @(posedge clk);
      chk({"R1 R2 ", lane_req(t.lanes)}, "first byte", 32'(byte_o), 32'(t.d0));
      chk("R8", "valid on completion", 32'(byte_vld_o), 32'd1);
      chk("R9", "rsp flag", 32'(rsp_o), 32'(t.rsp));
      send_bits(t.mode, t.lanes, t.rsp, t.d1, p, 1'b1, t.d0);
      @(posedge clk);
      chk({"R1 R2 ", lane_req(t.lanes)}, "second byte", 32'(byte_o), 32'(t.d1));
      chk("R8", "valid second byte", 32'(byte_vld_o), 32'd1);
      close_frame();
    end

    // R6 illegal lane width
    open_frame(2'd0, 2'd0, 1'b0);
    send_bits(2'd0, 2'd0, 1'b0, 8'h4D, 8, 1'b0, 8'h00);
    @(posedge clk);
    chk("R6", "legal lane err", 32'(lane_err_o), 32'd0);
    close_frame();
    open_frame(2'd0, 2'd3, 1'b1);
    @(posedge clk);
    chk("R6", "lane err flag", 32'(lane_err_o), 32'd1);
    send_bits(2'd0, 2'd3, 1'b1, 8'hB2, 8, 1'b0, 8'h00);
    @(posedge clk);
    chk("R6", "no valid when illegal", 32'(byte_vld_o), 32'd0);
    chk("R6", "byte unchanged when illegal", 32'(byte_o), 32'h4D);
    chk("R6", "rsp unchanged when illegal", 32'(rsp_o), 32'd0);
    close_frame();

    // R7 partial byte discarded across select
    open_frame(2'd3, 2'd0, 1'b0);
    send_bits(2'd3, 2'd0, 1'b0, 8'hFF, 3, 1'b0, 8'h00);
    close_frame();
    @(posedge clk);
    chk("R7", "partial gives no valid", 32'(byte_vld_o), 32'd0);
    chk("R7", "partial leaves byte", 32'(byte_o), 32'h4D);
    open_frame(2'd3, 2'd0, 1'b0);
    send_bits(2'd3, 2'd0, 1'b0, 8'h3C, 8, 1'b0, 8'h00);
    @(posedge clk);
    chk("R7", "fresh byte after discard", 32'(byte_o), 32'h3C);

    // R7/R9 select raised while valid stands
    chk("R8", "valid before deselect", 32'(byte_vld_o), 32'd1);
    @(negedge clk) csb_i = 1'b1;
    @(posedge clk);
    chk("R7", "valid cleared by deselect", 32'(byte_vld_o), 32'd0);
    chk("R9", "byte kept after deselect", 32'(byte_o), 32'h3C);

    // R3 response lane with rsp flag kept across deselect
    open_frame(2'd2, 2'd0, 1'b1);
    send_bits(2'd2, 2'd0, 1'b1, 8'hC9, 8, 1'b0, 8'h00);
    close_frame();
    @(posedge clk);
    chk("R3", "response lane byte", 32'(byte_o), 32'hC9);
    chk("R9", "rsp kept after deselect", 32'(rsp_o), 32'd1);

    // R10 reset clears held byte
    @(negedge clk) rst_ni = 1'b0;
    @(posedge clk);
    chk("R10", "byte after reset", 32'(byte_o), 32'd0);
    chk("R10", "rsp after reset", 32'(rsp_o), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule